// File: doc/BRIEF.md
# Receive Polarity Detect and Correct

This block decides whether the receive pair of a twisted-pair 10 Mb/s port is wired backwards, and holds that decision. At the end of every received frame an upstream classifier reports one frame-end strobe. The strobe carries two things: whether the end-of-transmission delimiter (ETD) was recognised as valid, and which polarity it was seen with. The block uses these events to drive an invert control for the receive data path. It also drives a status flag that shows reversed polarity, and a flag that shows the decision is locked.

After a hard reset or a link failure the block is armed. While armed, every valid ETD either sets a new reference polarity or agrees with the one already held. A run of `LOCK_COUNT` adjacent valid frames that agree locks the decision. The default of 2 gives two-frame confirmation. Once locked, the block ignores all ETD information. Only link failure or reset arms it again.

Top module: `rx_polarity_corrector`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it is released, `rx_invert`, `pol_reversed` and `pol_locked` are all 0.
- R2: The first valid-ETD frame after reset or link failure sets `rx_invert` to that frame's `etd_reversed` (1 = reversed, 0 = normal) on the clock edge where `frame_end` is high, whatever the earlier setting was.
- R3: A valid-ETD frame that directly follows a valid-ETD frame and agrees with the current `rx_invert` sets `pol_locked` to 1 on the same edge (with `LOCK_COUNT` = 2).
- R4: While unlocked, a valid-ETD frame that disagrees with `rx_invert` replaces it with the new polarity and leaves `pol_locked` at 0. That frame becomes the reference, so one more agreeing valid frame locks.
- R5: A frame-end event with `etd_valid` = 0 does not change `rx_invert`. It breaks the run, so the next valid frame acts as a first frame and does not lock.
- R6: While `pol_locked` is 1, frame-end events change neither `rx_invert` nor `pol_locked`, whatever their ETD fields are.
- R7: `link_fail` high at a clock edge clears `rx_invert` and `pol_locked` on that edge. It wins over a `frame_end` in the same cycle, and it re-arms the block.
- R8: `pol_reversed` equals `rx_invert` at all times: 1 while reversed polarity is applied, 0 under normal polarity.
- R9: With `frame_end` and `link_fail` both low, `rx_invert` and `pol_locked` hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hard reset, active low, synchronous |
| link_fail | input | 1 | Link failure, clears the decision and re-arms the block |
| frame_end | input | 1 | One-cycle strobe at the end of a received frame |
| etd_valid | input | 1 | The frame's ETD was classified as valid (qualifies `frame_end`) |
| etd_reversed | input | 1 | Polarity seen on the ETD: 1 = reversed, 0 = normal |
| rx_invert | output | 1 | Invert control for the receive data path |
| pol_reversed | output | 1 | Status: reversed polarity is being applied |
| pol_locked | output | 1 | The polarity decision is locked |

## Verification
The vector walk feeds the block several kinds of frame: valid ETD of either polarity, invalid ETD, agreeing pairs, disagreeing pairs, and idle gaps.
- A reversed first frame tells "set from the ETD" apart from "keep the reset value".
- An invalid frame between two valid ones tells a broken run apart from a run that only ignores invalid frames.
- A disagreement followed by an agreement shows that the newest ETD becomes the reference.
- Frames sent after locking, together with a link failure in the same cycle as a conflicting frame, check that ignoring and priority hold.
- A reset applied while locked checks the return to the armed state.

// File: rtl/rx_polarity_pkg.sv
package rx_polarity_pkg;

  // Event the decoder hands to the run counter and the invert register
  typedef enum logic [1:0] {
    EV_NONE  = 2'd0,
    EV_TAKE  = 2'd1,  // valid ETD that sets a new reference
    EV_AGREE = 2'd2,  // valid ETD that confirms the reference
    EV_BREAK = 2'd3   // invalid ETD, the run is broken
  } etd_event_e;

  // A valid ETD confirms only if a run is open and its polarity matches
  function automatic logic etd_confirms(input logic run_open,
                                        input logic seen_rev,
                                        input logic cur_inv);
    return run_open && (seen_rev == cur_inv);
  endfunction

  // Next run length for an event; link failure is handled by the caller
  function automatic int unsigned run_next(input etd_event_e ev,
                                           input int unsigned cur);
    case (ev)
      EV_TAKE:  return 1;
      EV_AGREE: return cur + 1;
      EV_BREAK: return 0;
      default:  return cur;
    endcase
  endfunction

endpackage

// File: rtl/etd_event_decode.sv
module etd_event_decode
  import rx_polarity_pkg::*;
(
  input  logic       frame_end,
  input  logic       etd_valid,
  input  logic       etd_reversed,
  input  logic       locked,
  input  logic       run_open,
  input  logic       cur_invert,
  output etd_event_e ev
);

  always_comb begin
    ev = EV_NONE;
    if (frame_end && !locked) begin
      if (!etd_valid)
        ev = EV_BREAK;
      else if (etd_confirms(run_open, etd_reversed, cur_invert))
        ev = EV_AGREE;
      else
        ev = EV_TAKE;
    end
  end

endmodule

// File: rtl/etd_run_counter.sv
module etd_run_counter
  import rx_polarity_pkg::*;
#(
  parameter int unsigned LOCK_COUNT = 2,
  localparam int unsigned RUN_W = $clog2(LOCK_COUNT + 1)
)(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       link_fail,
  input  etd_event_e ev,
  output logic       run_open,
  output logic       locked
);

  logic [RUN_W-1:0] run_q;
  logic [RUN_W-1:0] run_d;

  always_comb begin
    run_d = RUN_W'(run_next(ev, int'(run_q)));
  end

  always_ff @(posedge clk) begin
    if (!rst_n || link_fail)
      run_q <= '0;
    else
      run_q <= run_d;
  end

  assign run_open = (run_q != '0);
  assign locked   = (run_q == RUN_W'(LOCK_COUNT));

  // R6: once locked, only link failure can move the run
  assert_lock_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    locked && !link_fail |=> locked);

  // R7: link failure clears the lock on the same edge
  assert_fail_unlocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    link_fail |=> !locked);

  // R5: an invalid ETD leaves no open run
  assert_break_closes_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ev == EV_BREAK && !link_fail |=> !run_open);

endmodule

// File: rtl/rx_invert_reg.sv
module rx_invert_reg
  import rx_polarity_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       link_fail,
  input  etd_event_e ev,
  input  logic       etd_reversed,
  output logic       invert
);

  always_ff @(posedge clk) begin
    if (!rst_n || link_fail)
      invert <= 1'b0;
    else if (ev == EV_TAKE)
      invert <= etd_reversed;
  end

endmodule

// File: rtl/rx_polarity_corrector.sv
module rx_polarity_corrector
  import rx_polarity_pkg::*;
#(
  parameter int unsigned LOCK_COUNT = 2
)(
  input  logic clk,
  input  logic rst_n,
  input  logic link_fail,
  input  logic frame_end,
  input  logic etd_valid,
  input  logic etd_reversed,
  output logic rx_invert,
  output logic pol_reversed,
  output logic pol_locked
);

  // Internal events, brought out as named wires for the assertions
  etd_event_e ev;
  logic       run_open;
  logic       locked;
  logic       invert;

  etd_event_decode u_decode (
    .frame_end    (frame_end),
    .etd_valid    (etd_valid),
    .etd_reversed (etd_reversed),
    .locked       (locked),
    .run_open     (run_open),
    .cur_invert   (invert),
    .ev           (ev)
  );

  etd_run_counter #(.LOCK_COUNT(LOCK_COUNT)) u_run (
    .clk       (clk),
    .rst_n     (rst_n),
    .link_fail (link_fail),
    .ev        (ev),
    .run_open  (run_open),
    .locked    (locked)
  );

  rx_invert_reg u_inv (
    .clk          (clk),
    .rst_n        (rst_n),
    .link_fail    (link_fail),
    .ev           (ev),
    .etd_reversed (etd_reversed),
    .invert       (invert)
  );

  assign rx_invert    = invert;
  assign pol_reversed = invert;
  assign pol_locked   = locked;

  // R2 / R4: an armed valid frame leaves the invert control at its polarity
  assert_follow_etd_R2: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end && etd_valid && !pol_locked && !link_fail
      |=> rx_invert == $past(etd_reversed));

  // R5: an invalid ETD never moves the invert control
  assert_invalid_keeps_R5: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end && !etd_valid && !link_fail |=> $stable(rx_invert));

  // R6: locked decision is frozen
  assert_locked_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pol_locked && !link_fail |=> $stable(rx_invert));

  // R7: link failure returns the invert control to normal
  assert_fail_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    link_fail |=> !rx_invert);

  // R9: nothing moves between frames
  assert_idle_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_end && !link_fail |=> $stable(rx_invert) && $stable(pol_locked));

  // R3: a lock only ever follows a valid frame that agreed
  assert_lock_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pol_locked) |-> $past(frame_end && etd_valid && !link_fail
                                 && etd_reversed == rx_invert));

endmodule

// File: tb/rx_polarity_corrector_bench.sv
module rx_polarity_corrector_bench;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic link_fail = 1'b0;
  logic frame_end = 1'b0;
  logic etd_valid = 1'b0;
  logic etd_reversed = 1'b0;
  logic rx_invert, pol_reversed, pol_locked;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  rx_polarity_corrector u_rx_polarity_corrector (
    .clk          (clk),
    .rst_n        (rst_n),
    .link_fail    (link_fail),
    .frame_end    (frame_end),
    .etd_valid    (etd_valid),
    .etd_reversed (etd_reversed),
    .rx_invert    (rx_invert),
    .pol_reversed (pol_reversed),
    .pol_locked   (pol_locked)
  );

  // Stimulus bits {link_fail, frame_end, etd_valid, etd_reversed} and the
  // expected {rx_invert, pol_locked} after the edge that samples them
  typedef struct packed {
    logic [3:0] stim;
    logic [1:0] expv;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{4'b0111, 2'b10},  // R2 first valid ETD, reversed
    '{4'b0000, 2'b10},  // R9 idle holds
    '{4'b0100, 2'b10},  // R5 invalid keeps polarity, breaks run
    '{4'b0111, 2'b10},  // R5 after break this is a first frame, no lock
    '{4'b0110, 2'b00},  // R4 disagreement takes new polarity
    '{4'b0110, 2'b01},  // R3 agreeing second frame locks
    '{4'b0111, 2'b01},  // R6 conflicting frame ignored
    '{4'b0100, 2'b01},  // R6 invalid frame ignored
    '{4'b1000, 2'b00},  // R7 link failure clears
    '{4'b0111, 2'b10},  // R2 re-armed, takes reversed
    '{4'b0111, 2'b11},  // R3 locks reversed
    '{4'b1110, 2'b00},  // R7 link failure beats same-cycle frame
    '{4'b0110, 2'b00},  // R2 first frame after failure
    '{4'b0110, 2'b01}   // R3 lock on normal polarity
  };

  localparam string TAGS [NV] = '{"R2", "R9", "R5", "R5", "R4", "R3", "R6",
                                  "R6", "R7", "R2", "R3", "R7", "R2", "R3"};

  task automatic check(input string tag, input string what,
                       input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
    end
  endtask

  task automatic check_all(input string tag, input logic e_inv,
                           input logic e_lk);
    check(tag, "rx_invert", rx_invert, e_inv);
    check(tag, "pol_locked", pol_locked, e_lk);
    check("R8", "pol_reversed", pol_reversed, e_inv);
  endtask

  task automatic drive(input logic [3:0] s);
    @(negedge clk);
    {link_fail, frame_end, etd_valid, etd_reversed} = s;
    @(negedge clk);
    {link_fail, frame_end, etd_valid, etd_reversed} = 4'b0000;
  endtask

  initial begin
    // R1: state while in reset and just after release
    repeat (3) @(negedge clk);
    check_all("R1", 1'b0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1", 1'b0, 1'b0);

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i].stim);
      check_all(TAGS[i], VECS[i].expv[1], VECS[i].expv[0]);
    end

    // R1: hard reset while locked re-arms
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check_all("R1", 1'b0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1", 1'b0, 1'b0);

    // r2_: reversed first frame after reset, then a disagreeing pair (R4)
    drive(4'b0111);
    check_all("R2", 1'b1, 1'b0);
    drive(4'b0110);
    check_all("R4", 1'b0, 1'b0);
    drive(4'b0111);
    check_all("R4", 1'b1, 1'b0);
    // R9: several idle cycles hold the armed state
    repeat (4) @(negedge clk);
    check_all("R9", 1'b1, 1'b0);
    drive(4'b0111);
    check_all("R3", 1'b1, 1'b1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures",
             checks, fails);
    $finish;
  end

  initial begin
    #(20 * 5000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures",
               checks, fails);
      $finish;
    end
  end

endmodule